// File: doc/BRIEF.md
# Block-Matching Difference Tile

This tile scores how well one 4x4 reference block matches one 4x4 current block. Both blocks are written row by row over two 32-bit buses, each carrying four 8-bit pixels. Each of the sixteen pixel positions keeps its own current pixel and its own reference pixel, and forms the absolute difference between them. Four row adders reduce each row of differences to a partial sum. A final adder combines the four partial sums into the sum of absolute differences (SAD) for the whole block.

A compute strobe captures the block SAD into an output register, so a higher level can merge it with the results of neighbouring tiles. The strobe also carries the candidate's signed displacement. A local tracker keeps the smallest SAD seen since the last clear, together with the displacement that produced it. The current block can stay loaded while reference blocks for successive search positions are streamed in.

Top module: `sad_tile`

## Requirements
- R1: After reset `sad_o` is 0, `sad_valid_o` is 0, `best_sad_o` is 4095 (all ones) and both best vector components are 0.
- R2: While `cur_we_i` (or `ref_we_i`) is high at a clock edge, the word on `cur_row_i` (or `ref_row_i`) is stored in row `row_sel_i` of the current (or reference) block. Bits [8c+7:8c] hold column c. Both blocks may be written in the same cycle.
- R3: Each pixel position contributes |current - reference|, a value from 0 to 255. Swapping the two blocks gives the same SAD.
- R4: When `calc_i` is high at a clock edge, `sad_o` takes the sum of the sixteen pixel differences held at that edge. `sad_valid_o` is high for exactly the following cycle.
- R5: When no strobe occurs, `sad_o` holds its value and `sad_valid_o` is low.
- R6: Writing reference rows alone leaves every current pixel unchanged, so the later SAD is formed against the resident current block.
- R7: On a strobe the best SAD and vector are replaced only when the new SAD is strictly smaller than the held best. An equal or larger SAD leaves both unchanged.
- R8: `best_clr_i` sets the best SAD to 4095 and the vector to (0,0). When it coincides with a strobe, the clear applies first, so the strobe's SAD and vector become the best.
- R9: A strobe in the same cycle as a row write scores the block contents from before that write.
- R10: The largest SAD, 4080 (sixteen differences of 255), is reported without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_sel_i | input | 2 | Row index for writes |
| cur_we_i | input | 1 | Write current-block row |
| cur_row_i | input | 32 | Four current pixels, column 0 in the low byte |
| ref_we_i | input | 1 | Write reference-block row |
| ref_row_i | input | 32 | Four reference pixels, column 0 in the low byte |
| calc_i | input | 1 | Compute strobe |
| mv_x_i | input | 8 | Signed horizontal displacement of this candidate |
| mv_y_i | input | 8 | Signed vertical displacement of this candidate |
| best_clr_i | input | 1 | Reset the best SAD and vector |
| sad_o | output | 12 | Registered block SAD |
| sad_valid_o | output | 1 | One-cycle pulse after a strobe |
| best_sad_o | output | 12 | Smallest SAD since clear |
| best_mv_x_o | output | 8 | Horizontal displacement of the best |
| best_mv_y_o | output | 8 | Vertical displacement of the best |

## Verification
The main function is driven with several block pairs:
- A graded ramp pair gives a mid-range SAD.
- The same pair swapped separates a true absolute value from a one-sided difference.
- A pair that matches except for one pixel pins down the byte and row placement.
- An all-255 against all-zero pair probes adder width.

The tracker is then exercised with an equal SAD, a larger SAD, a clear on its own and a clear with a strobe. Row writes that coincide with a strobe, and reference-only reloads, expose any mix-up of timing or register sharing.

// File: rtl/sad_tile_pkg.sv
package sad_tile_pkg;
  localparam int unsigned MV_W = 8;

  typedef struct packed {
    logic signed [MV_W-1:0] x;
    logic signed [MV_W-1:0] y;
  } mv_t;

  localparam mv_t MV_ZERO = '{x: '0, y: '0};
endpackage

// File: rtl/sad_pix_unit.sv
module sad_pix_unit #(
  parameter int unsigned PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cur_we_i,
  input  logic             ref_we_i,
  input  logic [PIX_W-1:0] cur_pix_i,
  input  logic [PIX_W-1:0] ref_pix_i,
  output logic [PIX_W-1:0] diff_o
);
  logic [PIX_W-1:0] cur_q, ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      ref_q <= '0;
    end else begin
      if (cur_we_i) cur_q <= cur_pix_i;
      if (ref_we_i) ref_q <= ref_pix_i;
    end
  end

  always_comb begin
    if (cur_q >= ref_q) diff_o = cur_q - ref_q;
    else                diff_o = ref_q - cur_q;
  end

  // current pixel stays resident unless its own write is asserted
  assert_cur_resident_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur_we_i |=> $stable(cur_q));
  assert_ref_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_we_i |=> ref_q == $past(ref_pix_i));
endmodule

// File: rtl/sad_row_adder.sv
module sad_row_adder #(
  parameter int unsigned IN_W  = 8,
  parameter int unsigned N     = 4,
  parameter int unsigned OUT_W = IN_W + $clog2(N)
) (
  input  logic [N*IN_W-1:0] terms_i,
  output logic [OUT_W-1:0]  sum_o
);
  always_comb begin
    sum_o = '0;
    for (int i = 0; i < N; i++) begin
      sum_o = sum_o + OUT_W'(terms_i[i*IN_W +: IN_W]);
    end
  end
endmodule

// File: rtl/sad_best_tracker.sv
module sad_best_tracker
  import sad_tile_pkg::*;
#(
  parameter int unsigned SAD_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [SAD_W-1:0] sad_i,
  input  mv_t              mv_i,
  output logic [SAD_W-1:0] best_sad_o,
  output mv_t              best_mv_o
);
  logic [SAD_W-1:0] best_sad_q, base_sad;
  mv_t              best_mv_q, base_mv;
  logic             take;

  // clear is applied ahead of the comparison
  always_comb begin
    base_sad = clr_i ? '1 : best_sad_q;
    base_mv  = clr_i ? MV_ZERO : best_mv_q;
    take     = upd_i && (sad_i < base_sad);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_sad_q <= '1;
      best_mv_q  <= MV_ZERO;
    end else begin
      best_sad_q <= take ? sad_i : base_sad;
      best_mv_q  <= take ? mv_i  : base_mv;
    end
  end

  assign best_sad_o = best_sad_q;
  assign best_mv_o  = best_mv_q;

  assert_best_monotone_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> best_sad_q <= $past(best_sad_q));
  assert_best_take_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clr_i && sad_i < best_sad_q) |=> (best_sad_q == $past(sad_i) && best_mv_q == $past(mv_i)));
  assert_best_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(upd_i && sad_i < best_sad_q)) |=> ($stable(best_sad_q) && $stable(best_mv_q)));
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !upd_i) |=> (&best_sad_q && best_mv_q == MV_ZERO));
endmodule

// File: rtl/sad_tile.sv
module sad_tile
  import sad_tile_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned COLS  = 4,
  parameter int unsigned ROWS  = 4,
  localparam int unsigned ROW_W    = PIX_W * COLS,
  localparam int unsigned SEL_W    = $clog2(ROWS),
  localparam int unsigned RSUM_W   = PIX_W + $clog2(COLS),
  localparam int unsigned SAD_W    = RSUM_W + $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  row_sel_i,
  input  logic              cur_we_i,
  input  logic [ROW_W-1:0]  cur_row_i,
  input  logic              ref_we_i,
  input  logic [ROW_W-1:0]  ref_row_i,
  input  logic              calc_i,
  input  logic [MV_W-1:0]   mv_x_i,
  input  logic [MV_W-1:0]   mv_y_i,
  input  logic              best_clr_i,
  output logic [SAD_W-1:0]  sad_o,
  output logic              sad_valid_o,
  output logic [SAD_W-1:0]  best_sad_o,
  output logic [MV_W-1:0]   best_mv_x_o,
  output logic [MV_W-1:0]   best_mv_y_o
);
  logic [ROWS*RSUM_W-1:0] row_sums;
  logic [SAD_W-1:0]       total;
  logic [SAD_W-1:0]       sad_q;
  logic                   valid_q;
  mv_t                    cand_mv, best_mv;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic             row_hit;
    logic [ROW_W-1:0] diffs;
    assign row_hit = (row_sel_i == SEL_W'(r));

    for (genvar c = 0; c < COLS; c++) begin : g_col
      sad_pix_unit #(.PIX_W(PIX_W)) u_pix (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cur_we_i  (cur_we_i && row_hit),
        .ref_we_i  (ref_we_i && row_hit),
        .cur_pix_i (cur_row_i[c*PIX_W +: PIX_W]),
        .ref_pix_i (ref_row_i[c*PIX_W +: PIX_W]),
        .diff_o    (diffs[c*PIX_W +: PIX_W])
      );
    end

    sad_row_adder #(.IN_W(PIX_W), .N(COLS), .OUT_W(RSUM_W)) u_row_sum (
      .terms_i (diffs),
      .sum_o   (row_sums[r*RSUM_W +: RSUM_W])
    );
  end

  sad_row_adder #(.IN_W(RSUM_W), .N(ROWS), .OUT_W(SAD_W)) u_block_sum (
    .terms_i (row_sums),
    .sum_o   (total)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sad_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= calc_i;
      if (calc_i) sad_q <= total;
    end
  end

  assign cand_mv = '{x: mv_x_i, y: mv_y_i};

  sad_best_tracker #(.SAD_W(SAD_W)) u_best (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (best_clr_i),
    .upd_i      (calc_i),
    .sad_i      (total),
    .mv_i       (cand_mv),
    .best_sad_o (best_sad_o),
    .best_mv_o  (best_mv)
  );

  assign sad_o       = sad_q;
  assign sad_valid_o = valid_q;
  assign best_mv_x_o = best_mv.x;
  assign best_mv_y_o = best_mv.y;

  assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    calc_i |=> sad_valid_o);
  assert_sad_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !calc_i |=> (!sad_valid_o && $stable(sad_o)));
  assert_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sad_valid_o |-> sad_o <= SAD_W'(ROWS * COLS * ((1 << PIX_W) - 1)));
endmodule

// File: tb/sad_tile_tb.sv
module sad_tile_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  row_sel_i = '0;
  logic        cur_we_i = 1'b0, ref_we_i = 1'b0, calc_i = 1'b0, best_clr_i = 1'b0;
  logic [31:0] cur_row_i = '0, ref_row_i = '0;
  logic [7:0]  mv_x_i = '0, mv_y_i = '0;
  logic [11:0] sad_o, best_sad_o;
  logic        sad_valid_o;
  logic [7:0]  best_mv_x_o, best_mv_y_o;

  int checks = 0, errors = 0;
  bit done = 0;
  int cur_m[16], ref_m[16];
  int bsad = 4095, bmx = 0, bmy = 0;

  always #10 clk_i = ~clk_i;

  sad_tile u_dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_sad();
    int s = 0;
    for (int i = 0; i < 16; i++) s += (cur_m[i] > ref_m[i]) ? cur_m[i] - ref_m[i] : ref_m[i] - cur_m[i];
    return s;
  endfunction

  function automatic logic [31:0] row_word(input bit cur, input int r);
    logic [31:0] w;
    for (int c = 0; c < 4; c++) w[c*8 +: 8] = 8'(cur ? cur_m[r*4+c] : ref_m[r*4+c]);
    return w;
  endfunction

  task automatic write_rows(input bit do_cur, input bit do_ref);
    for (int r = 0; r < 4; r++) begin
      @(negedge clk_i);
      row_sel_i = 2'(r); cur_we_i = do_cur; ref_we_i = do_ref;
      cur_row_i = row_word(1, r); ref_row_i = row_word(0, r);
    end
    @(negedge clk_i);
    cur_we_i = 0; ref_we_i = 0;
  endtask

  task automatic strobe(input string req, input int mx, input int my, input bit clr, input int exp_sad);
    @(negedge clk_i);
    calc_i = 1; best_clr_i = clr; mv_x_i = 8'(mx); mv_y_i = 8'(my);
    @(negedge clk_i);
    calc_i = 0; best_clr_i = 0;
    if (clr) begin bsad = 4095; bmx = 0; bmy = 0; end
    if (exp_sad < bsad) begin bsad = exp_sad; bmx = mx; bmy = my; end
    chk(req, "sad_o", int'(sad_o), exp_sad);
    chk("R4", "sad_valid_o", int'(sad_valid_o), 1);
    chk(req, "best_sad_o", int'(best_sad_o), bsad);
    chk(req, "best_mv_x_o", int'($signed(best_mv_x_o)), bmx);
    chk(req, "best_mv_y_o", int'($signed(best_mv_y_o)), bmy);
  endtask

  task automatic t_reset();
    chk("R1", "sad_o", int'(sad_o), 0);
    chk("R1", "sad_valid_o", int'(sad_valid_o), 0);
    chk("R1", "best_sad_o", int'(best_sad_o), 4095);
    chk("R1", "best_mv_x_o", int'(best_mv_x_o), 0);
    chk("R1", "best_mv_y_o", int'(best_mv_y_o), 0);
  endtask

  task automatic t_ramp();
    for (int i = 0; i < 16; i++) begin cur_m[i] = (i * 13) % 256; ref_m[i] = i * 7 + 20; end
    write_rows(1, 1);
    strobe("R2", 1, -2, 0, model_sad());
    @(negedge clk_i);
    chk("R5", "sad_valid_o idle", int'(sad_valid_o), 0);
    chk("R5", "sad_o held", int'(sad_o), model_sad());
  endtask

  task automatic t_swap_equal();
    int tmp;
    for (int i = 0; i < 16; i++) begin tmp = cur_m[i]; cur_m[i] = ref_m[i]; ref_m[i] = tmp; end
    write_rows(1, 1);
    strobe("R3", 5, 5, 0, model_sad()); // equal SAD: R7 keeps earlier vector
  endtask

  task automatic t_max();
    for (int i = 0; i < 16; i++) begin cur_m[i] = 255; ref_m[i] = 0; end
    write_rows(1, 1);
    strobe("R10", 7, 7, 0, 4080); // larger: R7 no update
  endtask

  task automatic t_resident();
    for (int i = 0; i < 16; i++) ref_m[i] = 200 + (i % 5);
    write_rows(0, 1);
    strobe("R6", -1, 3, 0, model_sad());
  endtask

  task automatic t_single_pixel();
    for (int i = 0; i < 16; i++) begin cur_m[i] = 100; ref_m[i] = 100; end
    ref_m[2*4+3] = 40;
    write_rows(1, 1);
    strobe("R2", -3, 4, 0, 60);
  endtask

  task automatic t_clear();
    @(negedge clk_i);
    best_clr_i = 1;
    @(negedge clk_i);
    best_clr_i = 0;
    bsad = 4095; bmx = 0; bmy = 0;
    chk("R8", "best_sad_o after clear", int'(best_sad_o), 4095);
    chk("R8", "best_mv_x_o after clear", int'(best_mv_x_o), 0);
    chk("R8", "best_mv_y_o after clear", int'(best_mv_y_o), 0);
    chk("R8", "sad_o untouched", int'(sad_o), 60);
    strobe("R8", 9, -9, 1, 60);
  endtask

  task automatic t_overlap();
    int old_sad;
    old_sad = model_sad();
    for (int c = 0; c < 4; c++) cur_m[c] = 0;
    @(negedge clk_i);
    row_sel_i = 0; cur_we_i = 1; cur_row_i = row_word(1, 0); calc_i = 1;
    mv_x_i = 8'(2); mv_y_i = 8'(2);
    @(negedge clk_i);
    cur_we_i = 0; calc_i = 0;
    chk("R9", "sad_o uses old block", int'(sad_o), old_sad);
    strobe("R9", 3, 3, 0, model_sad());
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    t_ramp();
    t_swap_equal();
    t_max();
    t_resident();
    t_single_pixel();
    t_clear();
    t_overlap();
    repeat (2) @(negedge clk_i);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule